// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block sits beside one UART channel and turns its scattered interrupt conditions into a single status byte that software reads to learn why the channel raised its interrupt. Seven condition sources feed it. Each source has its own enable bit. The enabled, pending sources are ranked, and only the most urgent one is encoded into the status byte. A separate interrupt line goes high whenever any enabled source is pending.

The status byte is registered. It is frozen for as long as a bus read of it is in progress, so the value the bus sees cannot change under it. At the first cycle of a read, the block acknowledges the transmit-empty condition if that is the condition being reported. This clears its internal pending latch. All other sources are levels owned by their own status logic and are cleared there. The two top bits of the byte show whether the FIFOs are enabled.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset `intStatus` is 8'h01 and `irqOut` is 0.
- R2: The enabled pending source with the highest rank is reported in `intStatus[5:0]`. The ranks and codes, highest first, are:
  - line error: 6'b000110
  - receive ready: 6'b000100
  - receive timeout: 6'b001100
  - transmit empty: 6'b000010
  - modem change: 6'b000000
  - special character: 6'b010000
  - flow pin change: 6'b100000
- R3: With no enabled source pending, `intStatus[5:0]` is 6'b000001. Bit 0 is 0 whenever any source is reported.
- R4: `intStatus[7:6]` both equal `fifoEnable` as sampled at the last update.
- R5: `srcEnable` bit order is: bit 0 line error, 1 receive ready, 2 timeout, 3 transmit empty, 4 modem, 5 special character, 6 flow pin. A source whose bit is 0 is neither reported nor drives `irqOut`.
- R6: `irqOut` is 1 one cycle after any enabled source is pending, and 0 one cycle after none is. It keeps updating during a read.
- R7: While `readActive` is high, `intStatus` holds its value from before the read started.
- R8: A read start (`readActive` rising) while transmit-empty is reported clears the transmit-empty latch. A read start while another source is reported leaves the latch set.
- R9: A `txEmptyEvt` pulse sets the transmit-empty latch, which then stays pending until it is acknowledged. An event in the same cycle as an acknowledge wins, so the latch stays set.
- R10: With no read in progress, `intStatus` follows the pending sources one clock later. The transmit-empty latch adds one further clock after its event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| lineErr | input | 1 | Receive line status error pending |
| rxReady | input | 1 | Receive data ready pending |
| rxTimeout | input | 1 | Receive timeout pending |
| txEmptyEvt | input | 1 | One-cycle pulse: transmit holding went empty |
| modemChg | input | 1 | Modem status change pending |
| specialChar | input | 1 | Received Xon/Xoff or special character pending |
| flowPinChg | input | 1 | Flow-control pin change of state pending |
| srcEnable | input | 7 | Per-source enables, order as in R5 |
| fifoEnable | input | 1 | FIFOs enabled |
| readActive | input | 1 | High for the whole bus read of the status byte |
| intStatus | output | 8 | Encoded interrupt status byte |
| irqOut | output | 1 | Interrupt line, high when any enabled source pends |

## Verification
The bench targets several corner cases, and each has a visible symptom if the design gets it wrong.

- **Priority order.** It stacks all seven sources and removes them one at a time from the top. An inverted or shifted priority chain shows the wrong code at some step.
- **Frozen byte.** It changes the sources in the middle of a read. A status byte that is not frozen would show the new source during the read, and an `irqOut` that is wrongly frozen would lag.
- **Which read acknowledges.** It reads while a higher source masks transmit-empty. An acknowledge that ignores which source is reported would lose the transmit interrupt.
- **Event against acknowledge.** It fires a transmit event in the same cycle as the acknowledging read. Here an acknowledge that wins drops a fresh event.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC  = 7;
  localparam int CODE_W   = 6;
  localparam int STATUS_W = 8;
  localparam int FIFO_W   = STATUS_W - CODE_W;

  localparam int SRC_LINE  = 0;
  localparam int SRC_RXRDY = 1;
  localparam int SRC_RXTMO = 2;
  localparam int SRC_TXMT  = 3;
  localparam int SRC_MODEM = 4;
  localparam int SRC_SPCH  = 5;
  localparam int SRC_FLOW  = 6;

  localparam logic [CODE_W-1:0] CODE_NONE = 6'b000001;
  localparam logic [CODE_W-1:0] CODE_TX   = 6'b000010;

  typedef struct packed {
    logic freezeStatus;
    logic ackTx;
  } ctrlStrobe_t;

  function automatic logic [CODE_W-1:0] srcCode(input int idx);
    case (idx)
      SRC_LINE:  srcCode = 6'b000110;
      SRC_RXRDY: srcCode = 6'b000100;
      SRC_RXTMO: srcCode = 6'b001100;
      SRC_TXMT:  srcCode = CODE_TX;
      SRC_MODEM: srcCode = 6'b000000;
      SRC_SPCH:  srcCode = 6'b010000;
      SRC_FLOW:  srcCode = 6'b100000;
      default:   srcCode = CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N_SRC = NUM_SRC
) (
  input  logic [N_SRC-1:0]  gatedPend,
  output logic [CODE_W-1:0] winCode,
  output logic              anyPend
);
  // lowest rank first so the highest rank overwrites last
  always_comb begin
    winCode = CODE_NONE;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (gatedPend[i]) winCode = srcCode(i);
    end
  end

  assign anyPend = |gatedPend;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              readActive,
  input  logic [CODE_W-1:0] reportedCode,
  output ctrlStrobe_t       strobes
);
  logic prevRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevRead <= 1'b0;
    else       prevRead <= readActive;
  end

  logic readStart;
  assign readStart = readActive & ~prevRead;

  always_comb begin
    strobes.freezeStatus = readActive;
    strobes.ackTx        = readStart && (reportedCode == CODE_TX);
  end
endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int N_SRC = NUM_SRC
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [N_SRC-1:0]    levelFlags,
  input  logic                txEmptyEvt,
  input  logic [N_SRC-1:0]    srcEnable,
  input  logic                fifoEnable,
  input  ctrlStrobe_t         strobes,
  output logic [STATUS_W-1:0] intStatus,
  output logic                irqOut
);
  logic txPending;
  logic [N_SRC-1:0] pendVec;
  logic [N_SRC-1:0] gatedPend;
  logic [CODE_W-1:0] winCode;
  logic anyPend;

  // a new event outranks a same-cycle acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              txPending <= 1'b0;
    else if (txEmptyEvt)    txPending <= 1'b1;
    else if (strobes.ackTx) txPending <= 1'b0;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : gGate
    if (g == SRC_TXMT) begin : gTx
      assign pendVec[g] = txPending;
    end else begin : gLvl
      assign pendVec[g] = levelFlags[g];
    end
    assign gatedPend[g] = pendVec[g] & srcEnable[g];
  end

  uart_irq_prio #(.N_SRC(N_SRC)) uPrio (
    .gatedPend(gatedPend),
    .winCode  (winCode),
    .anyPend  (anyPend)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intStatus <= {{FIFO_W{1'b0}}, CODE_NONE};
      irqOut    <= 1'b0;
    end else begin
      irqOut <= anyPend;
      if (!strobes.freezeStatus)
        intStatus <= {{FIFO_W{fifoEnable}}, winCode};
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineErr,
  input  logic                rxReady,
  input  logic                rxTimeout,
  input  logic                txEmptyEvt,
  input  logic                modemChg,
  input  logic                specialChar,
  input  logic                flowPinChg,
  input  logic [NUM_SRC-1:0]  srcEnable,
  input  logic                fifoEnable,
  input  logic                readActive,
  output logic [STATUS_W-1:0] intStatus,
  output logic                irqOut
);
  logic [NUM_SRC-1:0] levelFlags;
  ctrlStrobe_t strobes;

  always_comb begin
    levelFlags = '0;
    levelFlags[SRC_LINE]  = lineErr;
    levelFlags[SRC_RXRDY] = rxReady;
    levelFlags[SRC_RXTMO] = rxTimeout;
    levelFlags[SRC_MODEM] = modemChg;
    levelFlags[SRC_SPCH]  = specialChar;
    levelFlags[SRC_FLOW]  = flowPinChg;
  end

  uart_irq_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .readActive  (readActive),
    .reportedCode(intStatus[CODE_W-1:0]),
    .strobes     (strobes)
  );

  uart_irq_datapath #(.N_SRC(NUM_SRC)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .levelFlags(levelFlags),
    .txEmptyEvt(txEmptyEvt),
    .srcEnable (srcEnable),
    .fifoEnable(fifoEnable),
    .strobes   (strobes),
    .intStatus (intStatus),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker
  import uart_irq_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                lineErr,
  input logic                rxReady,
  input logic                rxTimeout,
  input logic                txEmptyEvt,
  input logic                modemChg,
  input logic                specialChar,
  input logic                flowPinChg,
  input logic [NUM_SRC-1:0]  srcEnable,
  input logic                fifoEnable,
  input logic                readActive,
  input logic [STATUS_W-1:0] intStatus,
  input logic                irqOut
);
  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(readActive)) |-> $stable(intStatus));

  assert_none_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    intStatus[0] |-> (intStatus[CODE_W-1:0] == CODE_NONE));

  assert_fifo_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(readActive)) |->
      (intStatus[STATUS_W-1:CODE_W] == {FIFO_W{$past(fifoEnable)}}));

  assert_all_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(readActive) && ($past(srcEnable) == '0)) |->
      (intStatus[CODE_W-1:0] == CODE_NONE));

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(srcEnable) == '0)) |-> !irqOut);

  assert_line_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(readActive) && $past(lineErr && srcEnable[SRC_LINE])) |->
      (intStatus[CODE_W-1:0] == 6'b000110));
endmodule

bind uart_irq_ident uart_irq_checker uChk (.*);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineErr = 0, rxReady = 0, rxTimeout = 0, txEmptyEvt = 0;
  logic modemChg = 0, specialChar = 0, flowPinChg = 0;
  logic [6:0] srcEnable = '0;
  logic fifoEnable = 0, readActive = 0;
  logic [7:0] intStatus;
  logic irqOut;

  always #2.5 clk = ~clk;

  uart_irq_ident dut (.*);

  int nChecks = 0, nBad = 0;
  bit done = 0;

  // reference model built from the requirements
  logic [7:0] expStatus;
  logic expIrq, expTx, expPrev;

  function automatic logic [5:0] codeOf(input int idx);
    case (idx)
      0: return 6'b000110; 1: return 6'b000100; 2: return 6'b001100;
      3: return 6'b000010; 4: return 6'b000000; 5: return 6'b010000;
      6: return 6'b100000; default: return 6'b000001;
    endcase
  endfunction

  function automatic logic [5:0] pickCode(input logic [6:0] p);
    for (int i = 0; i < 7; i++) if (p[i]) return codeOf(i);
    return 6'b000001;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expStatus <= 8'h01; expIrq <= 0; expTx <= 0; expPrev <= 0;
    end else begin
      logic [6:0] g;
      logic ack;
      g = {flowPinChg, specialChar, modemChg, expTx, rxTimeout, rxReady, lineErr} & srcEnable;
      ack = readActive && !expPrev && (expStatus[5:0] == 6'b000010);
      expTx <= txEmptyEvt ? 1'b1 : (ack ? 1'b0 : expTx);
      if (!readActive) expStatus <= {{2{fifoEnable}}, pickCode(g)};
      expIrq <= |g;
      expPrev <= readActive;
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkModel(input string tag);
    nChecks++;
    if (intStatus !== expStatus || irqOut !== expIrq) begin
      nBad++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
               tag, intStatus, irqOut, expStatus, expIrq);
    end
  endtask

  task automatic chkCode(input string tag, input logic [5:0] want);
    nChecks++;
    if (intStatus[5:0] !== want) begin
      nBad++;
      $display("FAIL %s: code=%b expected %b", tag, intStatus[5:0], want);
    end
    chkModel(tag);
  endtask

  task automatic chkIrq(input string tag, input logic want);
    nChecks++;
    if (irqOut !== want) begin
      nBad++;
      $display("FAIL %s: irq=%b expected %b", tag, irqOut, want);
    end
  endtask

  task automatic pulseTx();
    txEmptyEvt = 1; step(); txEmptyEvt = 0;
  endtask

  task automatic readOnce();
    readActive = 1; step(); readActive = 0;
  endtask

  task automatic clearAll();
    {lineErr, rxReady, rxTimeout, modemChg, specialChar, flowPinChg} = '0;
  endtask

  initial begin
    process::self().srandom(32'd1234);
    step(3);
    nChecks++;
    if (intStatus !== 8'h01 || irqOut !== 1'b0) begin
      nBad++;
      $display("FAIL R1: status=%h irq=%b expected status=01 irq=0", intStatus, irqOut);
    end
    rstN = 1; step(2);
    chkModel("R1 after release");

    // R2 priority ladder, removing from the top
    srcEnable = 7'h7F;
    pulseTx();
    {lineErr, rxReady, rxTimeout, modemChg, specialChar, flowPinChg} = '1;
    step(3);
    chkCode("R2 line", 6'b000110);
    chkIrq("R6 pending", 1'b1);
    lineErr = 0;   step(2); chkCode("R2 rxready", 6'b000100);
    rxReady = 0;   step(2); chkCode("R2 timeout", 6'b001100);
    rxTimeout = 0; step(2); chkCode("R2 txempty", 6'b000010);
    readOnce(); step(2);
    chkCode("R8 ack clears tx", 6'b000000);
    modemChg = 0;    step(2); chkCode("R2 special", 6'b010000);
    specialChar = 0; step(2); chkCode("R2 flowpin", 6'b100000);
    flowPinChg = 0;  step(2); chkCode("R3 none", 6'b000001);
    chkIrq("R6 idle", 1'b0);

    // R4 fifo bits
    fifoEnable = 1; step(2);
    nChecks++;
    if (intStatus[7:6] !== 2'b11) begin
      nBad++; $display("FAIL R4: top=%b expected 11", intStatus[7:6]);
    end
    fifoEnable = 0; step(2); chkModel("R4 off");

    // R5 gating
    srcEnable = 7'h7E; lineErr = 1; step(2);
    chkCode("R5 masked", 6'b000001);
    chkIrq("R5 masked irq", 1'b0);
    srcEnable = 7'h7F; step(2);
    chkCode("R5 unmasked", 6'b000110);

    // R7 freeze, R6 irq keeps moving
    readActive = 1; step();
    lineErr = 0; rxReady = 1; step(3);
    chkCode("R7 frozen", 6'b000110);
    rxReady = 0; step(2);
    chkIrq("R6 during read", 1'b0);
    readActive = 0; step(2);
    chkCode("R7 released", 6'b000001);

    // R8 read while tx masked by higher source
    rxReady = 1; pulseTx(); step(3);
    chkCode("R8 rx over tx", 6'b000100);
    readOnce(); rxReady = 0; step(2);
    chkCode("R8 tx survives", 6'b000010);

    // R9 event beats acknowledge
    readActive = 1; txEmptyEvt = 1; step();
    readActive = 0; txEmptyEvt = 0; step(2);
    chkCode("R9 set wins", 6'b000010);
    readOnce(); step(2);
    chkCode("R9 then cleared", 6'b000001);

    // R10 random mix
    for (int c = 0; c < 4000; c++) begin
      lineErr     = ($urandom % 8) == 0;
      rxReady     = ($urandom % 5) == 0;
      rxTimeout   = ($urandom % 7) == 0;
      txEmptyEvt  = ($urandom % 9) == 0;
      modemChg    = ($urandom % 6) == 0;
      specialChar = ($urandom % 6) == 0;
      flowPinChg  = ($urandom % 4) == 0;
      if ($urandom % 16 == 0) srcEnable = 7'($urandom);
      if ($urandom % 32 == 0) fifoEnable = ~fifoEnable;
      readActive  = ($urandom % 4) == 0;
      step();
      chkModel("R10 random");
    end
    clearAll(); txEmptyEvt = 0; readActive = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nBad++;
      $display("FAIL watchdog: cycles=200000 expected completion");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule